// File: doc/BRIEF.md
# Eight-Point Fixed-Point Fourier Transform Engine

This block takes eight real, signed 8-bit samples presented side by side on one wide input bus and returns the eight complex frequency bins of their discrete Fourier transform. The computation is a radix-2 decimation-in-time network. The samples are first reordered by reversing their 3-bit indices. Three butterfly levels then follow, and the eight results are captured in output registers on the rising clock edge. A new sample set may be presented on every cycle, and the matching bins appear one cycle later.

Twiddles that are a power of -j cost no multiplier: they are handled by negation and by exchanging the real and imaginary parts. Only the odd eighth-roots of unity in the last level need real products. These use the constant 1/sqrt(2), held as 724/1024. Each product is rounded half away from zero, so the conjugate symmetry that a real input produces is kept bit-exact.

Top module: `fft8_dit`

## Requirements
- R1: Reset is synchronous and active low. At any rising edge where `rst_n` is 0, every output bit becomes 0, whatever the inputs are.
- R2: The outputs change only at a rising clock edge. The bins sampled after edge t are the transform of the inputs present at edge t, which gives a latency of exactly one cycle. Inputs that are held stable keep the outputs stable.
- R3: Bin 0 real equals the plain sum x0+x1+...+x7 exactly. Bin 4 real equals x0-x1+x2-x3+x4-x5+x6-x7 exactly. The imaginary parts of bins 0 and 4 are always 0.
- R4: Sample n is read from `smp_in[8n+7:8n]`, and bin k is driven on `bin_re[14k+13:14k]` and `bin_im[14k+13:14k]`. All values are two's complement. Every bin lies within 2 LSB of the ideal X(k) = sum over n of x(n)·exp(-j·2π·n·k/8).
- R5: For every input, bins k and 8-k (k = 1, 2, 3) are exact complex conjugates: the real parts are equal and the imaginary parts are negatives of each other.
- R6: A single nonzero sample A at an even position n, with all other samples 0, gives exact bins X(k) = A·(-j)^(n·k/2). Where (n·k mod 8) is 0, 2, 4 or 6, the bin is (A,0), (0,-A), (-A,0) or (0,A) respectively.
- R7: Full-scale inputs do not wrap. All samples at -128 give bin 0 real = -1024. All samples at 127 give bin 0 real = 1016. In both cases every other bin is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | 64 | Eight signed 8-bit samples, sample n in bits 8n+7:8n |
| bin_re | output | 112 | Real parts of the eight bins, bin k in bits 14k+13:14k |
| bin_im | output | 112 | Imaginary parts of the eight bins, bin k in bits 14k+13:14k |

## Verification
A wrong entry in the index permutation shows up as the wrong bin values one cycle after an impulse at the affected position. A wrong sign or a swapped part in a trivial twiddle has the same visible effect. The impulse sweep at every position and several amplitudes therefore exposes any single misrouted wire on the first vector that uses it. A fault in a real multiplier or in its rounding appears only in the odd bins. It breaks exact conjugate symmetry or moves those bins outside the 2-LSB band, and the pseudo-random vectors reach it within a few cycles. A broken output register or reset shows up as a zero or stale value at the very next sampling point.

// File: rtl/fft8_pkg.sv
// Shared sizes and types for the eight-point transform.
// Assumes a power-of-two point count and a twiddle constant in TW_FRAC fraction bits.
package fft8_pkg;
    localparam int NPT     = 8;                         // transform points
    localparam int LOG2N   = $clog2(NPT);               // butterfly levels
    localparam int IN_W    = 8;                         // input sample width
    localparam int OUT_W   = IN_W + LOG2N + 3;          // growth plus margin
    localparam int TW_FRAC = 10;                        // fraction bits of constant
    localparam int TW_C    = 724;                       // round(2^TW_FRAC / sqrt(2))
    localparam int TW_HALF = 1 << (TW_FRAC - 1);        // rounding offset

    typedef logic signed [OUT_W-1:0] samp_t;
    typedef struct packed {
        samp_t re;
        samp_t im;
    } cplx_t;
    typedef cplx_t [NPT-1:0] vec_t;
endpackage

// File: rtl/fft8_bitrev.sv
// Reorders the packed input samples by bit-reversed index and sign-extends
// them into complex words with zero imaginary part.
// Assumes sample n sits in raw[n*IN_W +: IN_W], two's complement.
module fft8_bitrev
    import fft8_pkg::*;
(
    input  logic [NPT*IN_W-1:0] raw,
    output vec_t                perm
);
    function automatic int rev_idx(input int v);
        int r;
        r = 0;
        for (int b = 0; b < LOG2N; b++) begin
            r = r | (((v >> b) & 1) << (LOG2N - 1 - b));
        end
        return r;
    endfunction

    for (genvar i = 0; i < NPT; i++) begin : g_perm
        localparam int SRC = rev_idx(i);
        // route sample SRC to slot i, extended to the internal width
        assign perm[i].re = {{(OUT_W-IN_W){raw[SRC*IN_W+IN_W-1]}}, raw[SRC*IN_W +: IN_W]};
        assign perm[i].im = '0;
    end
endmodule

// File: rtl/fft8_twiddle.sv
// Multiplies one complex word by W8^EXP. Exponents 0 and 2 use only routing
// and negation; 1 and 3 use the scaled 1/sqrt(2) constant with rounding half
// away from zero, so results for v and -v are exact negatives.
// Assumes EXP is one of 0..3 and operand sums fit in OUT_W+1 bits.
module fft8_twiddle
    import fft8_pkg::*;
#(
    parameter int EXP = 0
) (
    input  cplx_t din,
    output cplx_t dout
);
    function automatic samp_t scale_c(input logic signed [OUT_W:0] v);
        int p;
        int q;
        p = int'(v) * TW_C;
        if (p < 0) q = -((-p + TW_HALF) >>> TW_FRAC);
        else       q = (p + TW_HALF) >>> TW_FRAC;
        return samp_t'(q);
    endfunction

    logic signed [OUT_W:0] s_add;   // re + im
    logic signed [OUT_W:0] s_dif;   // im - re

    assign s_add = {din.re[OUT_W-1], din.re} + {din.im[OUT_W-1], din.im};
    assign s_dif = {din.im[OUT_W-1], din.im} - {din.re[OUT_W-1], din.re};

    if (EXP == 0) begin : g_one
        assign dout = din;
    end else if (EXP == 2) begin : g_mj
        // times -j: swap parts, negate the new imaginary part
        assign dout.re = din.im;
        assign dout.im = -din.re;
    end else if (EXP == 1) begin : g_w1
        // times c(1-j)
        assign dout.re = scale_c(s_add);
        assign dout.im = scale_c(s_dif);
    end else begin : g_w3
        // times -c(1+j)
        assign dout.re = scale_c(s_dif);
        assign dout.im = -scale_c(s_add);
    end
endmodule

// File: rtl/fft8_stage.sv
// One radix-2 butterfly level. Level STG pairs slots SPAN apart and applies
// twiddle W8^((pos)*NPT/(2*SPAN)) to the lower input of each pair.
// Assumes inputs arrive in the order the previous level leaves them.
module fft8_stage
    import fft8_pkg::*;
#(
    parameter int STG = 0
) (
    input  vec_t din,
    output vec_t dout
);
    localparam int SPAN   = 1 << STG;
    localparam int TWSTEP = (NPT / 2) / SPAN;

    for (genvar b = 0; b < NPT/2; b++) begin : g_bfly
        localparam int POS = b % SPAN;
        localparam int TOP = (b / SPAN) * 2 * SPAN + POS;
        localparam int BOT = TOP + SPAN;
        cplx_t prod;

        fft8_twiddle #(.EXP(POS * TWSTEP)) u_tw (
            .din  (din[BOT]),
            .dout (prod)
        );

        // upper and lower outputs share the single twiddle product
        assign dout[TOP].re = din[TOP].re + prod.re;
        assign dout[TOP].im = din[TOP].im + prod.im;
        assign dout[BOT].re = din[TOP].re - prod.re;
        assign dout[BOT].im = din[TOP].im - prod.im;

        // R4: the pair must sum to twice the upper input, exactly
        always_comb begin
            if (!$isunknown({din[TOP], dout[TOP], dout[BOT]})) begin
                a_r4_bfly_pair: assert (int'(dout[TOP].re) + int'(dout[BOT].re) == 2 * int'(din[TOP].re)
                                     && int'(dout[TOP].im) + int'(dout[BOT].im) == 2 * int'(din[TOP].im))
                    else $error("butterfly pair sum mismatch");
            end
        end
    end
endmodule

// File: rtl/fft8_dit.sv
// Eight-point decimation-in-time transform of real samples with registered
// complex outputs in natural bin order. One cycle latency, full throughput.
// Assumes synchronous active-low reset.
module fft8_dit
    import fft8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPT*IN_W-1:0]  smp_in,
    output logic [NPT*OUT_W-1:0] bin_re,
    output logic [NPT*OUT_W-1:0] bin_im
);
    vec_t lvl [LOG2N+1];

    fft8_bitrev u_perm (
        .raw  (smp_in),
        .perm (lvl[0])
    );

    for (genvar s = 0; s < LOG2N; s++) begin : g_lvl
        fft8_stage #(.STG(s)) u_stage (
            .din  (lvl[s]),
            .dout (lvl[s+1])
        );
    end

    // capture the final butterfly level, or clear under reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_re <= '0;
            bin_im <= '0;
        end else begin
            for (int k = 0; k < NPT; k++) begin
                bin_re[k*OUT_W +: OUT_W] <= lvl[LOG2N][k].re;
                bin_im[k*OUT_W +: OUT_W] <= lvl[LOG2N][k].im;
            end
        end
    end

    // R1: a reset edge leaves every output at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (bin_re == '0 && bin_im == '0));

    // R2: stable inputs after a working cycle keep outputs stable
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $stable(smp_in) |=> $stable(bin_re) && $stable(bin_im));

    // R3: bins 0 and 4 of a real input have no imaginary part
    a_r3_dc_imag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bin_im[0 +: OUT_W] == '0 && bin_im[(NPT/2)*OUT_W +: OUT_W] == '0);

    // R5: mirrored bins are exact conjugates
    for (genvar k = 1; k < NPT/2; k++) begin : g_conj
        a_r5_conj_pair: assert property (@(posedge clk) disable iff (!rst_n)
            bin_re[k*OUT_W +: OUT_W] == bin_re[(NPT-k)*OUT_W +: OUT_W]
            && OUT_W'(bin_im[k*OUT_W +: OUT_W] + bin_im[(NPT-k)*OUT_W +: OUT_W]) == '0);
    end
endmodule

// File: tb/fft8_dit_bench.sv
module fft8_dit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int IW = 8;
    localparam int OW = 14;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N*IW-1:0] smp_in;
    logic [N*OW-1:0] bin_re;
    logic [N*OW-1:0] bin_im;

    int n_chk  = 0;
    int n_err  = 0;
    int x [N];
    int prev_re [N];
    int prev_im [N];
    int lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    fft8_dit u_fft8_dit (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_in (smp_in),
        .bin_re (bin_re),
        .bin_im (bin_im)
    );

    function automatic int get_re(input int k);
        return int'($signed(bin_re[k*OW +: OW]));
    endfunction
    function automatic int get_im(input int k);
        return int'($signed(bin_im[k*OW +: OW]));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive();
        for (int n = 0; n < N; n++) smp_in[n*IW +: IW] = IW'(x[n]);
    endtask

    // entered at a negative edge; applies x, checks latency and all bin properties
    task automatic run_vec(input bit exact_imp, input int imp_pos);
        int sum;
        int alt;
        drive();
        #1;
        for (int k = 0; k < N; k++) begin
            check(get_re(k) == prev_re[k], "R2 no change before edge", get_re(k), prev_re[k]);
        end
        @(posedge clk);
        @(negedge clk);
        sum = 0;
        alt = 0;
        for (int n = 0; n < N; n++) begin
            sum += x[n];
            alt += (n % 2 == 0) ? x[n] : -x[n];
        end
        check(get_re(0) == sum, "R3 bin0 real", get_re(0), sum);
        check(get_re(4) == alt, "R3 bin4 real", get_re(4), alt);
        check(get_im(0) == 0 && get_im(4) == 0, "R3 bins 0/4 imag", get_im(0) | get_im(4), 0);
        for (int k = 0; k < N; k++) begin
            real rr;
            real ri;
            int er;
            int ei;
            rr = 0.0;
            ri = 0.0;
            for (int n = 0; n < N; n++) begin
                real ang;
                ang = 2.0 * 3.14159265358979 * real'(n * k) / real'(N);
                rr += real'(x[n]) * $cos(ang);
                ri -= real'(x[n]) * $sin(ang);
            end
            er = int'(rr);
            ei = int'(ri);
            check(get_re(k) - er <= 2 && er - get_re(k) <= 2, "R4 real within 2 LSB", get_re(k), er);
            check(get_im(k) - ei <= 2 && ei - get_im(k) <= 2, "R4 imag within 2 LSB", get_im(k), ei);
        end
        for (int k = 1; k < N/2; k++) begin
            check(get_re(k) == get_re(N-k), "R5 conj real", get_re(N-k), get_re(k));
            check(get_im(k) == -get_im(N-k), "R5 conj imag", get_im(N-k), -get_im(k));
        end
        if (exact_imp) begin
            int a;
            a = x[imp_pos];
            for (int k = 0; k < N; k++) begin
                int m;
                int xr;
                int xi;
                m = (imp_pos * k) % N;
                xr = (m == 0) ? a : (m == 4) ? -a : 0;
                xi = (m == 2) ? -a : (m == 6) ? a : 0;
                check(get_re(k) == xr, "R6 impulse real", get_re(k), xr);
                check(get_im(k) == xi, "R6 impulse imag", get_im(k), xi);
            end
        end
        for (int k = 0; k < N; k++) begin
            prev_re[k] = get_re(k);
            prev_im[k] = get_im(k);
        end
    endtask

    function automatic int next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int amps [5];
        amps = '{127, -128, 1, -1, 37};
        rst_n = 1'b0;
        for (int n = 0; n < N; n++) x[n] = 90 - 25 * n;
        drive();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state with nonzero inputs
        check(bin_re == '0 && bin_im == '0, "R1 reset outputs zero", int'(bin_re[31:0]), 0);
        for (int k = 0; k < N; k++) begin
            prev_re[k] = 0;
            prev_im[k] = 0;
        end
        rst_n = 1'b1;
        // R2: hold after release, the same input gives the same result twice
        run_vec(1'b0, 0);
        run_vec(1'b0, 0);
        check(get_re(1) == prev_re[1] && get_im(1) == prev_im[1], "R2 stable input holds", get_re(1), prev_re[1]);

        // R6/R4: impulse sweep over every position and amplitude
        for (int p = 0; p < N; p++) begin
            for (int a = 0; a < 5; a++) begin
                for (int n = 0; n < N; n++) x[n] = (n == p) ? amps[a] : 0;
                run_vec(p % 2 == 0, p);
            end
        end

        // R7: full scale both ways
        for (int n = 0; n < N; n++) x[n] = -128;
        run_vec(1'b0, 0);
        check(get_re(0) == -1024, "R7 full negative", get_re(0), -1024);
        for (int k = 1; k < N; k++)
            check(get_re(k) == 0 && get_im(k) == 0, "R7 other bins zero", get_re(k), 0);
        for (int n = 0; n < N; n++) x[n] = 127;
        run_vec(1'b0, 0);
        check(get_re(0) == 1016, "R7 full positive", get_re(0), 1016);

        // alternating extremes and ramps
        for (int n = 0; n < N; n++) x[n] = (n % 2 == 0) ? 127 : -128;
        run_vec(1'b0, 0);
        for (int n = 0; n < N; n++) x[n] = 16 * n - 64;
        run_vec(1'b0, 0);

        // pseudo-random sweep
        for (int v = 0; v < 400; v++) begin
            for (int n = 0; n < N; n++) x[n] = int'($signed(8'(next_rand())));
            run_vec(1'b0, 0);
        end

        // R1: reset in the middle of traffic clears at the next edge
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(bin_re == '0 && bin_im == '0, "R1 mid-run reset", int'(bin_re[31:0]), 0);
        rst_n = 1'b1;

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule